// File: doc/BRIEF.md
# Half-Bridge Lamp Drive Controller

This block turns a switching period, computed elsewhere by the lamp regulation loop, into two gate enables for the two transistors of a half bridge. Lamp power is set by frequency. The duty cycle does not set it. In run mode, each period is split into a low-side half and a high-side half. Each half starts with a programmable number of dead clocks, during which both switches are off.

An ignite mode shortens the conducting part of each half to a fraction of the available time. This gives a PWM drive for striking the lamp. Two fault flags remove both gate enables in the same clock cycle they are seen. The two flags are overvoltage, and lamp removal while the lamp is in normal running. A tripped fault is held until the mode is taken to off. The period, dead time, duty and run/ignite choice are sampled only at the start of a switching cycle, so a change never splits a half.

Top module: `lamp_bridge_drv`

## Requirements
- R1: While running, the internal cycle position steps once per clock and wraps after exactly the latched period, so each pattern repeats every period clocks.
- R2: For a latched period P and dead time D, let H = floor(P/2). In run mode, gate_lo is high at cycle positions D to H-1. gate_hi is high at positions H+D to 2H-1. Both are low elsewhere, including position P-1 when P is odd.
- R3: gate_lo and gate_hi are never high in the same cycle.
- R4: A requested period below 2*(D+4) is replaced by 2*(D+4). This includes a period of zero.
- R5: period_in, dead_in, duty_in and the run/ignite choice take effect only at the start of a switching cycle. A change in mid-cycle leaves the current cycle unchanged.
- R6: In ignite mode, each half conducts from its position D for floor((H-D)*duty_in/256) clocks. A duty of 0 gives no conduction.
- R7: When ovp_flag is high in run or ignite mode, both gate enables go low in that same cycle, before any clock edge.
- R8: When lamp_gone is high in run mode, both gates go low in that cycle. In ignite mode, lamp_gone has no effect on the gates or on fault.
- R9: A trip sets fault at the next clock edge. Fault then stays high, with both gates low, even after the flags clear, for as long as the mode stays run or ignite.
- R10: mode_sel encoding is 2'b00 off, 2'b01 run, 2'b10 ignite, and 2'b11 behaves as off. Off clears fault at the next edge and holds the gates low. The first clock edge in run or ignite starts a fresh cycle at position 0.
- R11: During and right after reset, gate_lo, gate_hi and fault are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | 00 off, 01 run, 10 ignite, 11 off |
| period_in | input | 8 | Requested switching period in clocks |
| dead_in | input | 5 | Dead time in clocks |
| duty_in | input | 8 | Ignite conduction fraction, in 1/256 units |
| ovp_flag | input | 1 | Overvoltage detected |
| lamp_gone | input | 1 | Lamp removal detected |
| gate_lo | output | 1 | Low-side switch enable |
| gate_hi | output | 1 | High-side switch enable |
| fault | output | 1 | Latched fault shutdown status |

## Verification
The drive pattern is tried with several inputs, and each one separates a different fault in the pattern logic. An even period checks the dead-time placement in both halves. An odd period checks that the longer second half still ends off. A zero dead time shows that conduction touches the half boundary, and a period at exactly the clamp limit and one below it separate the clamp from the normal path. Ignite vectors at duties of 128, 255 and 0 check the truncation arithmetic, and a period changed in mid-cycle shows that the new value is held back until the wrap. Fault sequences check the kill in the same cycle, the hold after the flags clear, the release through off, and that lamp removal does nothing during ignition.

// File: rtl/lbd_pkg.sv
package lbd_pkg;

    localparam int PER_W  = 8;
    localparam int DT_W   = 5;
    localparam int DUTY_W = 8;
    localparam int GUARD  = 4;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_RUN  = 2'b01,
        MODE_IGN  = 2'b10,
        MODE_IDLE = 2'b11
    } mode_e;

    typedef struct packed {
        logic [PER_W-1:0]  per;
        logic [DT_W-1:0]   dt;
        logic [DUTY_W-1:0] duty;
        logic              ign;
    } cyc_cfg_t;

    function automatic logic [PER_W-1:0] min_period(input logic [DT_W-1:0] dt);
        logic [PER_W:0] t;
        t = ({{(PER_W+1-DT_W){1'b0}}, dt} + (PER_W+1)'(GUARD)) << 1;
        return t[PER_W-1:0];
    endfunction

    function automatic logic is_active(input mode_e m);
        return (m == MODE_RUN) || (m == MODE_IGN);
    endfunction

endpackage

// File: rtl/lbd_cycle_ctr.sv
module lbd_cycle_ctr
    import lbd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  cyc_cfg_t         cfg_in,
    output logic             run_q,
    output logic [PER_W-1:0] cnt_q,
    output cyc_cfg_t         cfg_q
);

    logic             last;
    logic [PER_W-1:0] floor_per;
    cyc_cfg_t         cfg_clamped;

    assign last      = run_q && (cnt_q == cfg_q.per - 1'b1);
    assign floor_per = min_period(cfg_in.dt);

    always_comb begin
        cfg_clamped = cfg_in;
        if (cfg_in.per < floor_per) begin
            cfg_clamped.per = floor_per;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            run_q <= 1'b0;
            cnt_q <= '0;
            cfg_q <= '0;
        end else if (!run_q || last) begin
            run_q <= 1'b1;
            cnt_q <= '0;
            cfg_q <= cfg_clamped;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (cnt_q < cfg_q.per)); // R1
    AST_CLAMP_FLOOR: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (cfg_q.per >= min_period(cfg_q.dt))); // R4
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (run_q && !last && enable) |=> $stable(cfg_q)); // R5

endmodule

// File: rtl/lbd_phase_dec.sv
module lbd_phase_dec
    import lbd_pkg::*;
(
    input  logic             run_q,
    input  logic [PER_W-1:0] cnt_q,
    input  cyc_cfg_t         cfg_q,
    output logic             lo_raw,
    output logic             hi_raw
);

    localparam int PROD_W = PER_W + DUTY_W;

    logic [PER_W-1:0]  half;
    logic              second;
    logic [PER_W-1:0]  pos;
    logic [PER_W-1:0]  span;
    logic [PROD_W-1:0] prod;
    logic [PER_W-1:0]  on_len;
    logic [PER_W:0]    on_end;
    logic [PER_W-1:0]  dt_ext;
    logic              on;

    always_comb begin
        half   = cfg_q.per >> 1;
        second = (cnt_q >= half);
        pos    = second ? (cnt_q - half) : cnt_q;
        dt_ext = {{(PER_W-DT_W){1'b0}}, cfg_q.dt};
        span   = half - dt_ext;
        prod   = {{DUTY_W{1'b0}}, span} * {{PER_W{1'b0}}, cfg_q.duty};
        on_len = cfg_q.ign ? prod[PROD_W-1:DUTY_W] : span;
        on_end = {1'b0, dt_ext} + {1'b0, on_len};
        on     = run_q && (pos >= dt_ext) && ({1'b0, pos} < on_end);
        lo_raw = on && !second;
        hi_raw = on && second;
    end

endmodule

// File: rtl/lbd_fault_guard.sv
module lbd_fault_guard
    import lbd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  mode_e mode,
    input  logic  ovp_flag,
    input  logic  lamp_gone,
    output logic  trip,
    output logic  fault_q
);

    logic active;

    assign active = is_active(mode);
    assign trip   = active && (ovp_flag || (lamp_gone && (mode == MODE_RUN)));

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            fault_q <= 1'b0;
        end else if (trip) begin
            fault_q <= 1'b1;
        end
    end

    AST_TRIP_LATCH: assert property (@(posedge clk) disable iff (rst)
        (trip && active) |=> fault_q); // R9
    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (fault_q && active) |=> fault_q); // R9

endmodule

// File: rtl/lamp_bridge_drv.sv
module lamp_bridge_drv
    import lbd_pkg::*;
#(
    parameter int P_PER_W  = lbd_pkg::PER_W,
    parameter int P_DT_W   = lbd_pkg::DT_W,
    parameter int P_DUTY_W = lbd_pkg::DUTY_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          mode_sel,
    input  logic [P_PER_W-1:0]  period_in,
    input  logic [P_DT_W-1:0]   dead_in,
    input  logic [P_DUTY_W-1:0] duty_in,
    input  logic                ovp_flag,
    input  logic                lamp_gone,
    output logic                gate_lo,
    output logic                gate_hi,
    output logic                fault
);

    mode_e            mode;
    cyc_cfg_t         cfg_in;
    cyc_cfg_t         cfg_q;
    logic             run_q;
    logic [PER_W-1:0] cnt_q;
    logic             lo_raw;
    logic             hi_raw;
    logic             trip;
    logic             fault_q;
    logic             kill;
    logic             enable;

    assign mode   = mode_e'(mode_sel);
    assign cfg_in = '{per: period_in, dt: dead_in, duty: duty_in,
                      ign: (mode == MODE_IGN)};
    assign enable = is_active(mode) && !fault_q;

    lbd_fault_guard i_guard (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .ovp_flag (ovp_flag),
        .lamp_gone(lamp_gone),
        .trip     (trip),
        .fault_q  (fault_q)
    );

    lbd_cycle_ctr i_ctr (
        .clk   (clk),
        .rst   (rst),
        .enable(enable),
        .cfg_in(cfg_in),
        .run_q (run_q),
        .cnt_q (cnt_q),
        .cfg_q (cfg_q)
    );

    lbd_phase_dec i_dec (
        .run_q (run_q),
        .cnt_q (cnt_q),
        .cfg_q (cfg_q),
        .lo_raw(lo_raw),
        .hi_raw(hi_raw)
    );

    assign kill    = trip || fault_q;
    assign gate_lo = lo_raw && !kill;
    assign gate_hi = hi_raw && !kill;
    assign fault   = fault_q;

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(gate_lo && gate_hi)); // R3
    AST_OFF_RELEASE: assert property (@(posedge clk) disable iff (rst)
        !is_active(mode) |=> (!fault && !run_q)); // R10
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!fault && !gate_lo && !gate_hi)); // R11

endmodule

// File: tb/test_lamp_bridge_drv.sv
module test_lamp_bridge_drv;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode_sel = 2'b00;
    logic [7:0] period_in = '0;
    logic [4:0] dead_in = '0;
    logic [7:0] duty_in = '0;
    logic       ovp_flag = 1'b0;
    logic       lamp_gone = 1'b0;
    logic       gate_lo;
    logic       gate_hi;
    logic       fault;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    lamp_bridge_drv i_lamp_bridge_drv (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .period_in(period_in),
        .dead_in(dead_in), .duty_in(duty_in), .ovp_flag(ovp_flag),
        .lamp_gone(lamp_gone), .gate_lo(gate_lo), .gate_hi(gate_hi),
        .fault(fault)
    );

    // vector: {mode[22:21], period[20:13], dead[12:8], duty[7:0]}
    localparam logic [22:0] VEC [9] = '{
        {2'b01, 8'd40, 5'd3,  8'd0},
        {2'b01, 8'd41, 5'd0,  8'd0},
        {2'b01, 8'd20, 5'd6,  8'd0},
        {2'b01, 8'd10, 5'd5,  8'd0},
        {2'b10, 8'd60, 5'd4,  8'd128},
        {2'b10, 8'd50, 5'd2,  8'd255},
        {2'b10, 8'd30, 5'd1,  8'd0},
        {2'b01, 8'd0,  5'd31, 8'd0},
        {2'b11, 8'd40, 5'd3,  8'd0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int eff_per(input int p, input int dt);
        return (p < 2 * (dt + 4)) ? 2 * (dt + 4) : p;
    endfunction

    // returns {hi, lo}
    function automatic logic [1:0] model(input int c, input int p, input int dt,
                                         input int duty, input bit ign);
        int h, pos, span, on;
        bit sec;
        h    = p / 2;
        sec  = (c >= h);
        pos  = sec ? c - h : c;
        span = h - dt;
        on   = ign ? (span * duty) / 256 : span;
        if (pos >= dt && pos < dt + on) return sec ? 2'b10 : 2'b01;
        return 2'b00;
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic go_off();
        mode_sel = 2'b00;
        ovp_flag = 1'b0;
        lamp_gone = 1'b0;
        step();
        step();
    endtask

    initial begin
        #(8 * 150000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        // R11 reset state
        step();
        chk("R11 reset gates", {gate_hi, gate_lo}, 2'b00);
        chk("R11 reset fault", fault, 1'b0);
        step();
        rst = 1'b0;
        step();
        chk("R11 after reset", {fault, gate_hi, gate_lo}, 3'b000);

        // table walk: R2, R4, R6, R10, R3
        foreach (VEC[i]) begin
            int m, p, dt, du, pe;
            string tag;
            m  = VEC[i][22:21];
            p  = VEC[i][20:13];
            dt = VEC[i][12:8];
            du = VEC[i][7:0];
            pe = eff_per(p, dt);
            tag = (m == 3) ? "R10" : (m == 2) ? "R6" : (pe != p) ? "R4" : "R2";
            go_off();
            period_in = p[7:0];
            dead_in   = dt[4:0];
            duty_in   = du[7:0];
            mode_sel  = m[1:0];
            for (int j = 0; j < 2 * pe + 2; j++) begin
                logic [1:0] e;
                step();
                e = (m == 3) ? 2'b00 : model(j % pe, pe, dt, du, m == 2);
                chk(tag, {gate_hi, gate_lo}, e);
                chk("R3 overlap", gate_hi & gate_lo, 1'b0);
                chk("R1 no fault", fault, 1'b0);
            end
        end

        // R5: period change in mid-cycle waits for the wrap
        go_off();
        period_in = 8'd20; dead_in = 5'd2; duty_in = 8'd0; mode_sel = 2'b01;
        for (int j = 0; j < 50; j++) begin
            step();
            if (j < 20) chk("R5 old period", {gate_hi, gate_lo}, model(j, 20, 2, 0, 0));
            else        chk("R5 new period", {gate_hi, gate_lo}, model(j - 20, 30, 2, 0, 0));
            if (j == 5) period_in = 8'd30;
        end

        // R7 immediate kill, R9 hold, R10 release and restart
        go_off();
        period_in = 8'd20; dead_in = 5'd2; mode_sel = 2'b01;
        for (int j = 0; j < 6; j++) step();
        chk("R7 before trip", {gate_hi, gate_lo}, 2'b01);
        ovp_flag = 1'b1;
        #1;
        chk("R7 same-cycle kill", {gate_hi, gate_lo}, 2'b00);
        step();
        chk("R9 fault set", fault, 1'b1);
        ovp_flag = 1'b0;
        for (int j = 0; j < 25; j++) begin
            step();
            chk("R9 held off", {fault, gate_hi, gate_lo}, 3'b100);
        end
        mode_sel = 2'b00;
        step();
        chk("R10 off clears fault", fault, 1'b0);
        mode_sel = 2'b01;
        for (int j = 0; j < 20; j++) begin
            step();
            chk("R10 restart", {gate_hi, gate_lo}, model(j, 20, 2, 0, 0));
        end

        // R7 in ignite mode
        go_off();
        period_in = 8'd40; dead_in = 5'd2; duty_in = 8'd200; mode_sel = 2'b10;
        for (int j = 0; j < 5; j++) step();
        ovp_flag = 1'b1;
        #1;
        chk("R7 ignite kill", {gate_hi, gate_lo}, 2'b00);
        step();
        chk("R7 ignite fault", fault, 1'b1);

        // R8: lamp_gone ignored in ignite
        go_off();
        lamp_gone = 1'b1;
        period_in = 8'd40; dead_in = 5'd2; duty_in = 8'd200; mode_sel = 2'b10;
        for (int j = 0; j < 40; j++) begin
            step();
            chk("R8 ignite ignores", {fault, gate_hi, gate_lo}, {1'b0, model(j, 40, 2, 200, 1)});
        end

        // R8: lamp_gone trips in run
        mode_sel = 2'b00;
        step();
        mode_sel = 2'b01;
        for (int j = 0; j < 10; j++) begin
            step();
            chk("R8 run trip", {fault, gate_hi, gate_lo}, 3'b100);
        end

        go_off();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule